// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small processor core and decides, at each instruction boundary, whether to divert the core to a handler and which one. Event-type sources are captured into sticky flags. Level-type sources have no flag and request only while their input is high. Each source has its own enable bit, and one global enable gates all of them. When several sources are pending, the one with the lowest index wins. Vector slot 0 belongs to reset, so source `k` uses slot `k+1`.

The core asserts `step_i` at every instruction boundary where it can be interrupted. When the controller accepts a request, it raises `take_o` in that same cycle and presents `src_id_o` and `vec_addr_o`. On that clock edge it clears the global enable and clears the accepted event flag. A return-from-interrupt (`reti_i`) sets the global enable again. It also opens a guard, so that one more instruction boundary must pass before the next acceptance. Software can clear flags by writing ones to them. It can set the global enable inside a handler to allow nesting, and it can clear the global enable with immediate effect. A select input moves the vector table from address 0 to a boot region base.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all flags are 0, the global enable `gie_o` is 0 and `take_o` is 0.
- R2: A high `src_i[k]` on an event source sets `flag_o[k]` at the next edge. The flag stays set while the source enable or the global enable is off, until it is accepted or cleared.
- R3: `take_o` is 1 only in a cycle with `step_i`=1, `gie_o`=1, `gie_clr_i`=0 and at least one requesting source whose `en_i` bit is 1.
- R4: On acceptance, `src_id_o` is the lowest index among the enabled requesting sources.
- R5: `vec_addr_o` = base + (`src_id_o`+1)·SLOT_WORDS. The base is 0 when `vbase_boot_i`=0 and BOOT_BASE when it is 1. With the defaults (SLOT_WORDS=2, BOOT_BASE=0x3800), source 3 maps to 0x0008 and source 0 with the boot base maps to 0x3802.
- R6: The edge after `take_o`=1 clears `gie_o` and clears the accepted event flag, unless a new strobe for that same source arrives in the accept cycle.
- R7: A 1 in `flag_clr_i[k]` clears `flag_o[k]` at the next edge, and a 0 leaves it unchanged. A strobe in the same cycle wins, and the flag stays set.
- R8: Sources whose bit in LEVEL_MASK is 1 (by default source 7) never set a flag and request only while `src_i` is high. A pulse that ends while the source is disabled leaves nothing pending.
- R9: `reti_i` sets `gie_o` at the next edge. No acceptance happens until one cycle with `step_i`=1 has passed after the `reti_i` cycle.
- R10: `gie_set_i` sets `gie_o` at the next edge, including inside a handler, so that an enabled source can preempt it. `gie_clr_i` clears `gie_o` at the next edge and blocks acceptance in its own cycle. If both are asserted together, clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Request inputs: strobe for event sources, level for level sources |
| en_i | input | NUM_SRC | Per-source enable mask |
| flag_clr_i | input | NUM_SRC | Write-one-to-clear for flags |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable (immediate) |
| reti_i | input | 1 | Return from interrupt |
| step_i | input | 1 | Instruction boundary; core may be interrupted |
| vbase_boot_i | input | 1 | Vector base select: 0 = address 0, 1 = BOOT_BASE |
| take_o | output | 1 | Interrupt accepted this cycle |
| src_id_o | output | IDX_W | Index of the accepted source |
| vec_addr_o | output | ADDR_W | Handler vector address |
| flag_o | output | NUM_SRC | Pending event flags |
| gie_o | output | 1 | Global enable state |

## Verification
The assertions assume that `reti_i` is never asserted in the same cycle as `take_o`, since the core cannot return and accept at once. They also assume that `src_i` for a level source is held steady across an acceptance cycle. The directed tasks drive each control input for a single cycle and keep `reti_i` apart from `step_i`. Stimulus changes one cycle after a clock edge, and every combinational output is read before the next edge.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef enum logic {VB_APP = 1'b0, VB_BOOT = 1'b1} vbase_e;
endpackage

// File: rtl/irq_flags.sv
`timescale 1ns/1ps
module irq_flags #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'h80,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               take_i,
  input  logic [IDX_W-1:0]   id_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] req_o
);
  localparam logic [NUM_SRC-1:0] EVT_MASK = ~LEVEL_MASK;

  logic [NUM_SRC-1:0] flag_q, flag_d, take_clr;

  always_comb begin
    take_clr = '0;
    if (take_i) take_clr[id_i] = 1'b1;
    // new strobe wins over both clear paths
    flag_d = ((flag_q & ~clr_i & ~take_clr) | src_i) & EVT_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_lvl
      assign req_o[i] = src_i[i];
    end else begin : g_evt
      assign req_o[i] = flag_q[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   id_o
);
  logic [NUM_SRC-1:0] pend;

  always_comb begin
    pend = req_i & en_i;
    any_o = |pend;
    id_o = '0;
    // scan downward so the lowest index is left last
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) id_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec.sv
`timescale 1ns/1ps
module irq_vec #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16,
  parameter int SLOT_WORDS = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic              boot_i,
  input  logic [IDX_W-1:0]  id_i,
  output logic [ADDR_W-1:0] addr_o
);
  import irq_pkg::*;

  logic [ADDR_W-1:0] base, slot, off;

  always_comb begin
    base   = (vbase_e'(boot_i) == VB_BOOT) ? BOOT_BASE : '0;
    slot   = ADDR_W'(id_i) + ADDR_W'(1);  // slot 0 is reset
    off    = slot * ADDR_W'(SLOT_WORDS);
    addr_o = base + off;
  end
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic step_i,
  input  logic gie_set_i,
  input  logic gie_clr_i,
  input  logic reti_i,
  output logic take_o,
  output logic gie_o
);
  logic gie_q, gap_q;

  assign take_o = any_i & step_i & gie_q & ~gie_clr_i & ~gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      if (take_o || gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i || reti_i) gie_q <= 1'b1;

      if (reti_i)      gap_q <= 1'b1;
      else if (step_i) gap_q <= 1'b0;
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'h80,
  parameter int ADDR_W = 16,
  parameter int SLOT_WORDS = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               step_i,
  input  logic               vbase_boot_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   src_id_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] req;
  logic               any;
  logic [IDX_W-1:0]   id;

  irq_flags #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .clr_i(flag_clr_i),
    .take_i(take_o), .id_i(id), .flag_o(flag_o), .req_o(req)
  );

  irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .req_i(req), .en_i(en_i), .any_o(any), .id_o(id)
  );

  irq_vec #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS),
            .BOOT_BASE(BOOT_BASE)) u_vec (
    .boot_i(vbase_boot_i), .id_i(id), .addr_o(vec_addr_o)
  );

  irq_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .any_i(any), .step_i(step_i),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .reti_i(reti_i),
    .take_o(take_o), .gie_o(gie_o)
  );

  assign src_id_o = id;
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'h80,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic               gie_clr_i,
  input logic               reti_i,
  input logic               step_i,
  input logic               take_o,
  input logic [IDX_W-1:0]   src_id_o,
  input logic [NUM_SRC-1:0] flag_o,
  input logic               gie_o
);
  logic [NUM_SRC-1:0] pend, below;

  always_comb begin
    pend = (flag_o | (src_i & LEVEL_MASK)) & en_i;
    for (int i = 0; i < NUM_SRC; i++) below[i] = (i < int'(src_id_o));
  end

  a_r3_take_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (step_i && gie_o && !gie_clr_i));

  a_r4_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (pend[src_id_o] && ((pend & below) == '0)));

  a_r6_gie_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !gie_o);

  a_r6_flag_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !src_i[src_id_o]) |=> !flag_o[$past(src_id_o)]);

  a_r8_level_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_i[NUM_SRC-1]) && LEVEL_MASK[NUM_SRC-1] |=> !flag_o[NUM_SRC-1]);

  a_r9_gap_after_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reti_i) |-> !take_o);

  a_r10_clr_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |=> !gie_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .en_i(en_i),
  .gie_clr_i(gie_clr_i), .reti_i(reti_i), .step_i(step_i), .take_o(take_o),
  .src_id_o(src_id_o), .flag_o(flag_o), .gie_o(gie_o)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0, en_i = '0, flag_clr_i = '0;
  logic          gie_set_i = 0, gie_clr_i = 0, reti_i = 0, step_i = 0, vbase_boot_i = 0;
  logic          take_o, gie_o;
  logic [IW-1:0] src_id_o;
  logic [AW-1:0] vec_addr_o;
  logic [N-1:0]  flag_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .en_i(en_i), .flag_clr_i(flag_clr_i),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .reti_i(reti_i), .step_i(step_i),
    .vbase_boot_i(vbase_boot_i), .take_o(take_o), .src_id_o(src_id_o),
    .vec_addr_o(vec_addr_o), .flag_o(flag_o), .gie_o(gie_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulse_src(logic [N-1:0] v);
    src_i = v; cyc(); src_i = '0;
  endtask

  task automatic set_gie();
    gie_set_i = 1; cyc(); gie_set_i = 0;
  endtask

  task automatic t_reset();
    check("R1 flags", flag_o, 0);
    check("R1 gie", gie_o, 0);
    check("R1 take", take_o, 0);
  endtask

  task automatic t_pending();
    en_i = '1;
    pulse_src(8'h08);
    check("R2 flag set", flag_o, 8'h08);
    step_i = 1; #1;
    check("R3 no take gie off", take_o, 0);
    step_i = 0;
    en_i = 8'hF7;
    set_gie();
    check("R10 gie set", gie_o, 1);
    check("R2 still pending", flag_o, 8'h08);
    step_i = 1; #1;
    check("R3 no take src off", take_o, 0);
    en_i = '1; #1;
    check("R3 take", take_o, 1);
    check("R4 id", src_id_o, 3);
    check("R5 addr", vec_addr_o, 16'h0008);
    cyc(); step_i = 0;
    check("R6 gie cleared", gie_o, 0);
    check("R6 flag cleared", flag_o, 0);
  endtask

  task automatic t_priority();
    pulse_src(8'h24);
    set_gie();
    step_i = 1; #1;
    check("R4 lowest", src_id_o, 2);
    check("R5 addr id2", vec_addr_o, 16'h0006);
    cyc(); step_i = 0;
    check("R6 other flag kept", flag_o, 8'h20);
    flag_clr_i = 8'h20; cyc(); flag_clr_i = '0;
    check("R7 w1c", flag_o, 0);
    src_i = 8'h02; flag_clr_i = 8'h02; cyc(); src_i = '0; flag_clr_i = '0;
    check("R7 set wins", flag_o, 8'h02);
    flag_clr_i = 8'h01; cyc(); flag_clr_i = '0;
    check("R7 zero bits no effect", flag_o, 8'h02);
    flag_clr_i = 8'h02; cyc(); flag_clr_i = '0;
    check("R7 cleared", flag_o, 0);
  endtask

  task automatic t_level();
    en_i = 8'h7F;
    pulse_src(8'h80);
    cyc();
    en_i = '1;
    set_gie();
    check("R8 no flag", flag_o, 0);
    step_i = 1; #1;
    check("R8 gone no take", take_o, 0);
    src_i = 8'h80; #1;
    check("R8 level take", take_o, 1);
    check("R8 id", src_id_o, 7);
    check("R5 addr id7", vec_addr_o, 16'h0010);
    cyc(); src_i = '0; step_i = 0;
    check("R8 no flag after", flag_o, 0);
    check("R6 gie after level", gie_o, 0);
  endtask

  task automatic t_boot();
    vbase_boot_i = 1;
    pulse_src(8'h01);
    set_gie();
    step_i = 1; #1;
    check("R5 boot addr", vec_addr_o, 16'h3802);
    check("R4 id0", src_id_o, 0);
    cyc(); step_i = 0; vbase_boot_i = 0;
  endtask

  task automatic t_gap();
    pulse_src(8'h08);
    reti_i = 1; cyc(); reti_i = 0;
    check("R9 reti sets gie", gie_o, 1);
    step_i = 1; #1;
    check("R9 gap blocks", take_o, 0);
    cyc();
    check("R9 take after one insn", take_o, 1);
    check("R9 id", src_id_o, 3);
    cyc(); step_i = 0;
  endtask

  task automatic t_disable_nested();
    pulse_src(8'h08);
    set_gie();
    step_i = 1; gie_clr_i = 1; #1;
    check("R10 clr blocks same cycle", take_o, 0);
    cyc(); step_i = 0; gie_clr_i = 0;
    check("R10 gie off", gie_o, 0);
    check("R2 kept after disable", flag_o, 8'h08);
    gie_set_i = 1; gie_clr_i = 1; cyc(); gie_set_i = 0; gie_clr_i = 0;
    check("R10 clr wins", gie_o, 0);
    set_gie();
    step_i = 1; #1;
    check("R3 take outer", take_o, 1);
    cyc(); step_i = 0;
    pulse_src(8'h02);
    set_gie();
    step_i = 1; #1;
    check("R10 nested take", take_o, 1);
    check("R10 nested id", src_id_o, 1);
    cyc(); step_i = 0;
    check("R6 nested flags", flag_o, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1; cyc();
    t_reset();
    t_pending();
    t_priority();
    t_level();
    t_boot();
    t_gap();
    t_disable_nested();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule